// File: doc/BRIEF.md
# DS3 Idle Signal Detector

This block watches a received DS3 bit stream and decides, once per M-frame, whether the far end is sending the idle signal. An upstream framer that is already in frame supplies each bit together with its position: subframe, block within the subframe, and bit within the block. Bit 0 of a block is its overhead bit. Bits 1 to 84 are payload.

In an idle frame, the payload carries a repeating 1,1,0,0 sequence that restarts with a 1,1 pair after every overhead bit. The three C-bits of the third subframe must all be zero. Payload is judged in 4-bit groups. A frame still qualifies with up to five errored groups and is rejected with six or more. The block also reports the two received X-bits. It combines them with the idle verdict into a full idle indication that is set only when all three are 1.

Top module: `ds3_idle_det`

## Requirements
- R1: Payload bit n of a block (n = 1..84) is expected to be 1 when (n-1) mod 4 is 0 or 1, and 0 when it is 2 or 3. The sequence restarts after every overhead bit, so a payload that is out of phase (0,0,1,1) fails.
- R2: Payload bits n = 4k+1..4k+4 form one group. A group counts as one error if any of its bits is wrong, however many of its bits are wrong.
- R3: A complete frame with at most 5 errored groups and zero C-bits sets idle_o to 1 at the clock edge that accepts the frame's last bit (subframe 6, block 7, bit 84).
- R4: A frame with 6 or more errored groups clears idle_o at that same edge.
- R5: If any overhead bit at subframe 2, blocks 2, 4 or 6 is 1, the frame clears idle_o.
- R6: All other overhead bits have no effect on idle_o.
- R7: x1_o takes the data at subframe 0, block 0, bit 0, and x2_o takes the data at subframe 1, block 0, bit 0. Each updates on the edge that accepts that bit and holds until the next frame.
- R8: idle_full_o is 1 exactly when idle_o, x1_o and x2_o are all 1.
- R9: While pos_ok_i is low, idle_o is 0 from the next edge on. A frame qualifies only if it was accepted from its first bit with pos_ok_i high throughout.
- R10: idle_o changes only at a frame's last bit or on loss of position. It holds its value through the rest of the frame.
- R11: After reset, idle_o, x1_o, x2_o and idle_full_o are 0.
- R12: Each frame is judged on its own. Errored groups and C-bits from earlier frames do not carry over.
- R13: A cycle with bit_en_i low is ignored, whatever data_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Marks a cycle that carries a received bit |
| data_i | input | 1 | Received DS3 bit |
| pos_ok_i | input | 1 | Framer is in frame and the position inputs are valid |
| sf_i | input | 3 | Subframe index, 0..6 |
| blk_i | input | 3 | Block index within the subframe, 0..7 |
| bit_i | input | 7 | Bit index within the block, 0 is overhead, 1..84 payload |
| idle_o | output | 1 | Idle verdict of the last complete frame |
| x1_o | output | 1 | Last received X1 bit |
| x2_o | output | 1 | Last received X2 bit |
| idle_full_o | output | 1 | Idle verdict and both X-bits are 1 |

## Verification
The assertions assume that the position inputs step through the frame in order whenever pos_ok_i is high. They also assume that bit 0 of subframe 0 block 0 is the only frame start and bit 84 of subframe 6 block 7 the only frame end. The bench always walks the full 4760-bit order with in-range indices. It inserts random idle cycles with bit_en_i low and garbage data between bits. It drops pos_ok_i for exactly one accepted bit inside a frame and never sends an index outside the legal ranges.

// File: rtl/ds3_idle_pkg.sv
package ds3_idle_pkg;
  localparam int unsigned SUBFRAMES   = 7;
  localparam int unsigned BLOCKS      = 8;
  localparam int unsigned PAY_BITS    = 84;
  localparam int unsigned GRP_BITS    = 4;
  localparam int unsigned MAX_ERR_GRP = 5;
  localparam int unsigned C_SUBFRAME  = 2;
  localparam int unsigned X1_SUBFRAME = 0;
  localparam int unsigned X2_SUBFRAME = 1;

  typedef struct packed {
    logic frm_start;
    logic frm_end;
    logic payload;
    logic x1;
    logic x2;
    logic c_chk;
  } pos_dec_t;
endpackage

// File: rtl/ds3_idle_pos.sv
module ds3_idle_pos
  import ds3_idle_pkg::*;
#(
  parameter int unsigned SUBFRAMES_P = SUBFRAMES,
  parameter int unsigned BLOCKS_P    = BLOCKS,
  parameter int unsigned PAY_BITS_P  = PAY_BITS,
  parameter int unsigned C_SF_P      = C_SUBFRAME,
  parameter int unsigned X1_SF_P     = X1_SUBFRAME,
  parameter int unsigned X2_SF_P     = X2_SUBFRAME,
  localparam int unsigned SF_W  = $clog2(SUBFRAMES_P),
  localparam int unsigned BLK_W = $clog2(BLOCKS_P),
  localparam int unsigned BIT_W = $clog2(PAY_BITS_P + 1)
) (
  input  logic [SF_W-1:0]  sf_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [BIT_W-1:0] bit_i,
  output pos_dec_t         dec_o
);
  localparam logic [SF_W-1:0]  SF_LAST  = SF_W'(SUBFRAMES_P - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCKS_P - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(PAY_BITS_P);
  localparam logic [SF_W-1:0]  SF_C     = SF_W'(C_SF_P);
  localparam logic [SF_W-1:0]  SF_X1    = SF_W'(X1_SF_P);
  localparam logic [SF_W-1:0]  SF_X2    = SF_W'(X2_SF_P);

  logic oh, blk0, c_blk;

  assign oh    = (bit_i == '0);
  assign blk0  = (blk_i == '0);
  // C-bits sit on the overhead of even, non-zero blocks
  assign c_blk = !blk_i[0] && !blk0;

  always_comb begin
    dec_o           = '0;
    dec_o.frm_start = oh && blk0 && (sf_i == '0);
    dec_o.frm_end   = (sf_i == SF_LAST) && (blk_i == BLK_LAST) && (bit_i == BIT_LAST);
    dec_o.payload   = !oh;
    dec_o.x1        = oh && blk0 && (sf_i == SF_X1);
    dec_o.x2        = oh && blk0 && (sf_i == SF_X2);
    dec_o.c_chk     = oh && c_blk && (sf_i == SF_C);
  end
endmodule

// File: rtl/ds3_idle_pattern.sv
module ds3_idle_pattern #(
  parameter int unsigned PAY_BITS_P    = 84,
  parameter int unsigned GRP_BITS_P    = 4,
  parameter int unsigned MAX_ERR_GRP_P = 5,
  localparam int unsigned BIT_W = $clog2(PAY_BITS_P + 1),
  localparam int unsigned PH_W  = $clog2(GRP_BITS_P),
  localparam int unsigned ERR_W = $clog2(MAX_ERR_GRP_P + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             pay_stb_i,
  input  logic             data_i,
  input  logic [BIT_W-1:0] bit_i,
  output logic             pat_ok_o
);
  localparam logic [ERR_W-1:0] ERR_SAT = ERR_W'(MAX_ERR_GRP_P + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = ERR_W'(MAX_ERR_GRP_P);
  localparam logic [PH_W-1:0]  PH_HALF = PH_W'(GRP_BITS_P / 2);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(GRP_BITS_P - 1);

  logic [BIT_W-1:0] pay_off;
  logic [PH_W-1:0]  phase;
  logic             exp_bit, miss, grp_bad, grp_done;
  logic             grp_err_q;
  logic [ERR_W-1:0] err_q, err_nxt;

  assign pay_off  = bit_i - BIT_W'(1);
  assign phase    = pay_off[PH_W-1:0];
  assign exp_bit  = (phase < PH_HALF);
  assign miss     = data_i ^ exp_bit;
  assign grp_bad  = grp_err_q | miss;
  assign grp_done = pay_stb_i && (phase == PH_LAST);

  // saturate one past the limit, that is all the verdict needs
  always_comb begin
    err_nxt = err_q;
    if (grp_done && grp_bad && (err_q != ERR_SAT)) err_nxt = err_q + ERR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q     <= '0;
      grp_err_q <= 1'b0;
    end else if (clr_i) begin
      err_q     <= '0;
      grp_err_q <= 1'b0;
    end else if (pay_stb_i) begin
      err_q     <= err_nxt;
      grp_err_q <= (phase == PH_LAST) ? 1'b0 : grp_bad;
    end
  end

  // includes the group closing on this very bit
  assign pat_ok_o = (err_nxt <= ERR_MAX);
endmodule

// File: rtl/ds3_idle_oh.sv
module ds3_idle_oh
  import ds3_idle_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     stb_i,
  input  logic     data_i,
  input  pos_dec_t dec_i,
  output logic     c_ok_o,
  output logic     x1_o,
  output logic     x2_o
);
  logic c_ok_q, x1_q, x2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_ok_q <= 1'b0;
      x1_q   <= 1'b0;
      x2_q   <= 1'b0;
    end else if (stb_i) begin
      if (dec_i.frm_start)  c_ok_q <= 1'b1;
      else if (dec_i.c_chk) c_ok_q <= c_ok_q & ~data_i;
      if (dec_i.x1) x1_q <= data_i;
      if (dec_i.x2) x2_q <= data_i;
    end
  end

  assign c_ok_o = c_ok_q;
  assign x1_o   = x1_q;
  assign x2_o   = x2_q;
endmodule

// File: rtl/ds3_idle_det.sv
module ds3_idle_det
  import ds3_idle_pkg::*;
#(
  parameter int unsigned SUBFRAMES_P   = SUBFRAMES,
  parameter int unsigned BLOCKS_P      = BLOCKS,
  parameter int unsigned PAY_BITS_P    = PAY_BITS,
  parameter int unsigned GRP_BITS_P    = GRP_BITS,
  parameter int unsigned MAX_ERR_GRP_P = MAX_ERR_GRP,
  localparam int unsigned SF_W  = $clog2(SUBFRAMES_P),
  localparam int unsigned BLK_W = $clog2(BLOCKS_P),
  localparam int unsigned BIT_W = $clog2(PAY_BITS_P + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             data_i,
  input  logic             pos_ok_i,
  input  logic [SF_W-1:0]  sf_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [BIT_W-1:0] bit_i,
  output logic             idle_o,
  output logic             x1_o,
  output logic             x2_o,
  output logic             idle_full_o
);
  pos_dec_t dec;
  logic     stb, pat_ok, c_ok, full_q, idle_q;

  assign stb = bit_en_i && pos_ok_i;

  ds3_idle_pos #(
    .SUBFRAMES_P (SUBFRAMES_P),
    .BLOCKS_P    (BLOCKS_P),
    .PAY_BITS_P  (PAY_BITS_P),
    .C_SF_P      (C_SUBFRAME),
    .X1_SF_P     (X1_SUBFRAME),
    .X2_SF_P     (X2_SUBFRAME)
  ) u_pos (
    .sf_i  (sf_i),
    .blk_i (blk_i),
    .bit_i (bit_i),
    .dec_o (dec)
  );

  ds3_idle_pattern #(
    .PAY_BITS_P    (PAY_BITS_P),
    .GRP_BITS_P    (GRP_BITS_P),
    .MAX_ERR_GRP_P (MAX_ERR_GRP_P)
  ) u_pat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (stb && dec.frm_start),
    .pay_stb_i (stb && dec.payload),
    .data_i    (data_i),
    .bit_i     (bit_i),
    .pat_ok_o  (pat_ok)
  );

  ds3_idle_oh u_oh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (stb),
    .data_i (data_i),
    .dec_i  (dec),
    .c_ok_o (c_ok),
    .x1_o   (x1_o),
    .x2_o   (x2_o)
  );

  // full_q: frame was accepted from its first bit without loss of position
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      idle_q <= 1'b0;
    end else if (!pos_ok_i) begin
      full_q <= 1'b0;
      idle_q <= 1'b0;
    end else if (bit_en_i) begin
      if (dec.frm_start) full_q <= 1'b1;
      if (dec.frm_end)   idle_q <= full_q && pat_ok && c_ok;
    end
  end

  assign idle_o      = idle_q;
  assign idle_full_o = idle_q && x1_o && x2_o;
endmodule

// File: rtl/ds3_idle_chk.sv
module ds3_idle_chk #(
  parameter int unsigned SF_W  = 3,
  parameter int unsigned BLK_W = 3,
  parameter int unsigned BIT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_en_i,
  input logic             data_i,
  input logic             pos_ok_i,
  input logic [SF_W-1:0]  sf_i,
  input logic [BLK_W-1:0] blk_i,
  input logic [BIT_W-1:0] bit_i,
  input logic             idle_o,
  input logic             x1_o,
  input logic             x2_o,
  input logic             idle_full_o
);
  logic acc, at_start, at_end, at_x1, at_x2, at_c;
  logic seen_q, c_hit_q;

  assign acc      = bit_en_i && pos_ok_i;
  assign at_start = (sf_i == 0) && (blk_i == 0) && (bit_i == 0);
  assign at_end   = (sf_i == 6) && (blk_i == 7) && (bit_i == 84);
  assign at_x1    = at_start;
  assign at_x2    = (sf_i == 1) && (blk_i == 0) && (bit_i == 0);
  assign at_c     = (sf_i == 2) && (bit_i == 0) && ((blk_i == 2) || (blk_i == 4) || (blk_i == 6));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      c_hit_q <= 1'b0;
    end else begin
      if (!pos_ok_i) seen_q <= 1'b0;
      else if (acc && at_start) seen_q <= 1'b1;
      if (acc && at_start) c_hit_q <= 1'b0;
      else if (acc && at_c && data_i) c_hit_q <= 1'b1;
    end
  end

  AST_IDLE_DROPS_ON_POS_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pos_ok_i |=> !idle_o); // R9
  AST_PARTIAL_FRAME_REJECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && at_end && !seen_q) |=> !idle_o); // R9
  AST_IDLE_HELD_MID_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_ok_i && !(bit_en_i && at_end)) |=> $stable(idle_o)); // R10
  AST_C_BIT_REJECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && at_end && c_hit_q) |=> !idle_o); // R5
  AST_X1_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && at_x1) |=> (x1_o == $past(data_i))); // R7
  AST_X2_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && at_x2) |=> (x2_o == $past(data_i))); // R7
  AST_X1_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && at_x1) |=> $stable(x1_o)); // R7
  AST_FULL_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_full_o |-> idle_o); // R8
  AST_FULL_NEEDS_XBITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!x1_o || !x2_o) |-> !idle_full_o); // R8
  AST_IGNORE_DISABLED_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_en_i && pos_ok_i) |=> ($stable(idle_o) && $stable(x1_o) && $stable(x2_o))); // R13
endmodule

bind ds3_idle_det ds3_idle_chk #(
  .SF_W  (SF_W),
  .BLK_W (BLK_W),
  .BIT_W (BIT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_en_i    (bit_en_i),
  .data_i      (data_i),
  .pos_ok_i    (pos_ok_i),
  .sf_i        (sf_i),
  .blk_i       (blk_i),
  .bit_i       (bit_i),
  .idle_o      (idle_o),
  .x1_o        (x1_o),
  .x2_o        (x2_o),
  .idle_full_o (idle_full_o)
);

// File: tb/sim_ds3_idle_det.sv
module sim_ds3_idle_det;
  localparam int CLK_PERIOD = 10;
  localparam int N_GRP      = 7 * 8 * 21;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, data = 1'b0, pos_ok = 1'b0;
  logic [2:0] sf = '0, blk = '0;
  logic [6:0] bidx = '0;
  logic       idle, x1, x2, idle_full;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  bit  exp_idle = 1'b0;
  bit  err_map [N_GRP];
  logic [3:0] err_msk [N_GRP];

  always #(CLK_PERIOD/2) clk = ~clk;

  ds3_idle_det u0 (
    .clk_i (clk), .rst_ni (rst_n), .bit_en_i (bit_en), .data_i (data),
    .pos_ok_i (pos_ok), .sf_i (sf), .blk_i (blk), .bit_i (bidx),
    .idle_o (idle), .x1_o (x1), .x2_o (x2), .idle_full_o (idle_full)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // expected idle payload bit for payload position n (1..84)
  function automatic bit pay_bit(int n);
    return ((n - 1) % 4) < 2;
  endfunction

  function automatic bit verdict(int nerr, bit cbad, bit shift, bit full);
    return full && !cbad && !shift && (nerr <= 5);
  endfunction

  task automatic put_bit(int s, int b, int n, bit d, bit pv);
    while ($urandom_range(0, 7) == 0) begin
      @(negedge clk);
      bit_en = 1'b0;
      data   = 1'($urandom);   // R13: garbage on idle cycles
    end
    @(negedge clk);
    sf = 3'(s); blk = 3'(b); bidx = 7'(n);
    bit_en = 1'b1; pos_ok = pv; data = d;
  endtask

  // nerr errored groups with per-group mask; cbad bit k hits C-bit k; drop>=0 loses position at that bit
  task automatic send_frame(int nerr, int msk_mode, bit [2:0] cbad, bit shift,
                            bit xb1, bit xb2, int drop, string tag);
    int base, idx, cnt;
    bit full, v, d;
    foreach (err_map[i]) begin err_map[i] = 1'b0; err_msk[i] = '0; end
    base = $urandom_range(0, N_GRP - 1);
    for (int k = 0; k < nerr; k++) begin
      idx = (base + k * 97) % N_GRP;
      err_map[idx] = 1'b1;
      err_msk[idx] = (msk_mode == 0) ? 4'($urandom_range(1, 15)) : 4'(msk_mode);
    end
    full = (drop < 0);
    cnt = 0;
    for (int s = 0; s < 7; s++)
      for (int b = 0; b < 8; b++)
        for (int n = 0; n <= 84; n++) begin
          if (s == 3 && b == 0 && n == 0) begin
            @(negedge clk);
            chk({"R10 mid-frame hold ", tag}, idle, exp_idle);
          end
          if (n == 0) begin
            if (s == 0 && b == 0)      d = xb1;
            else if (s == 1 && b == 0) d = xb2;
            else if (s == 2 && (b == 2 || b == 4 || b == 6)) d = cbad[b/2 - 1];
            else d = 1'($urandom);   // R6
          end else begin
            idx = (s * 8 + b) * 21 + (n - 1) / 4;
            v = pay_bit(n) ^ shift;
            if (err_map[idx] && err_msk[idx][(n - 1) % 4]) v = ~v;
            d = v;
          end
          put_bit(s, b, n, d, !(cnt == drop));
          if (cnt == drop) begin
            @(negedge clk);
            bit_en = 1'b0; pos_ok = 1'b1;
            exp_idle = 1'b0;
            chk({"R9 idle low after position loss ", tag}, idle, 0);
          end
          cnt++;
        end
    @(negedge clk);
    bit_en = 1'b0;
    exp_idle = verdict(nerr, |cbad, shift, full);
    chk({"R3/R4/R5 idle verdict ", tag}, idle, exp_idle);
    chk({"R7 x1 ", tag}, x1, xb1);
    chk({"R7 x2 ", tag}, x2, xb2);
    chk({"R8 full idle ", tag}, idle_full, exp_idle && xb1 && xb2);
  endtask

  initial begin
    void'($urandom(32'h5eed_0d53));
    repeat (3) @(negedge clk);
    chk("R11 reset idle", idle, 0);
    chk("R11 reset x1", x1, 0);
    chk("R11 reset x2", x2, 0);
    chk("R11 reset full", idle_full, 0);
    rst_n  = 1'b1;
    pos_ok = 1'b1;
    send_frame(0, 0, 3'b000, 1'b0, 1'b1, 1'b1, -1, "R1 clean");
    send_frame(5, 15, 3'b000, 1'b0, 1'b1, 1'b1, -1, "R2 five full groups");
    send_frame(6, 1, 3'b000, 1'b0, 1'b1, 1'b1, -1, "R4 six single-bit");
    send_frame(0, 0, 3'b000, 1'b0, 1'b1, 1'b1, -1, "R12 recover");
    send_frame(5, 0, 3'b000, 1'b0, 1'b1, 1'b1, -1, "R3 five random");
    send_frame(0, 0, 3'b000, 1'b1, 1'b1, 1'b1, -1, "R1 shifted");
    send_frame(0, 0, 3'b001, 1'b0, 1'b1, 1'b1, -1, "R5 C7");
    send_frame(0, 0, 3'b010, 1'b0, 1'b1, 1'b1, -1, "R5 C8");
    send_frame(0, 0, 3'b100, 1'b0, 1'b1, 1'b1, -1, "R5 C9");
    send_frame(0, 0, 3'b000, 1'b0, 1'b0, 1'b1, -1, "R8 x1 low");
    send_frame(0, 0, 3'b000, 1'b0, 1'b1, 1'b0, -1, "R8 x2 low");
    send_frame(0, 0, 3'b000, 1'b0, 1'b1, 1'b1, 900, "R9 drop");
    send_frame(0, 0, 3'b000, 1'b0, 1'b1, 1'b1, -1, "R9 after drop");
    for (int r = 0; r < 4; r++)
      send_frame($urandom_range(0, 9), 0, ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000,
                 1'b0, 1'($urandom), 1'($urandom), -1, "R12 random");
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule